// File: doc/BRIEF.md
# Keyboard Controller Host Register Front End

This block is the host-side register front end of a PC-style controller for a keyboard and an auxiliary pointing device. The host sees two byte-wide ports. Port select 0 is the data port. Port select 1 is the command port on writes and the status port on reads. The block decodes controller command bytes and owns the mode and status registers. It turns each host access into one-cycle strobes toward the neighbouring logic: the keyboard and auxiliary output queues, the keyboard and auxiliary device links, and the system output port.

Some command bytes do not act when they arrive. Instead they arm a one-shot target, and the next data-port write goes to that target. Other commands answer at once by pushing a reply byte into the keyboard output queue. The queues themselves sit outside the block and report only whether they hold data. The block combines those two flags with the mode register to raise the two interrupt lines, and with its own flags to form the status byte.

Top module: `kbc_hostregs`

## Requirements
- R1: After reset the mode register is 0x03, the status byte reads 0x18 when both queues are empty, no write target is armed, and all strobes and `xlatEn` are low.
- R2: A command-port read loads `rdData` with the status byte on the next clock edge. The status bits are: bit 0 = either queue holds data, bit 2 = self-test passed, bit 3 = last host write went to the command port, bit 4 = 1 (unlocked), bit 5 = the aux queue holds data and the keyboard queue is empty. All other bits are 0. A data-port read leaves `rdData` unchanged.
- R3: Command 0x20 pushes the current mode register into the keyboard queue (`kbdPush` with `outByte` = mode).
- R4: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 arm the next data write. 0x60 loads it into mode, 0xD1 sends it to the output port, 0xD2 pushes it to the keyboard queue, 0xD3 pushes it to the aux queue, and 0xD4 forwards it to the aux device. Other commands leave an armed target in place. Any data write disarms it.
- R5: A data write with nothing armed is forwarded to the keyboard device (`kbdFwd`, `outByte` = data).
- R6: Command 0xAA sets status bit 2, which then stays set until reset, and pushes 0x55. Commands 0xA9 and 0xAB push 0x00, and command 0xC0 pushes 0x80.
- R7: Commands 0xA7 and 0xA8 set and clear mode bit 5. Commands 0xAD and 0xAE set and clear mode bit 4.
- R8: `irqKbd` = keyboard queue has data AND mode bit 0 AND NOT mode bit 4. `irqAux` = aux queue has data AND keyboard queue empty AND mode bit 1. The two are never high together.
- R9: `xlatEn` equals mode bit 6.
- R10: A command-port write sets status bit 3, and a data-port write clears it.
- R11: A command byte outside the listed set causes no strobe and changes neither mode nor status, apart from bit 3.
- R12: Every strobe lasts one cycle and rises on the clock edge after the write. At most one of `kbdPush`, `auxPush`, `kbdFwd`, `auxFwd`, `outPortWr` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hostWr | input | 1 | Single-cycle host write strobe |
| hostRd | input | 1 | Single-cycle host read strobe |
| hostSel | input | 1 | 0 = data port, 1 = command/status port |
| hostWdata | input | 8 | Host write byte |
| kbdHasData | input | 1 | Keyboard output queue is non-empty |
| auxHasData | input | 1 | Aux output queue is non-empty |
| rdData | output | 8 | Status byte captured by the last command-port read |
| kbdPush | output | 1 | Push `outByte` into the keyboard queue |
| auxPush | output | 1 | Push `outByte` into the aux queue |
| kbdFwd | output | 1 | Send `outByte` to the keyboard device |
| auxFwd | output | 1 | Send `outByte` to the aux device |
| outPortWr | output | 1 | Write `outByte` to the system output port |
| outByte | output | 8 | Byte carried by the active strobe |
| irqKbd | output | 1 | Keyboard interrupt level |
| irqAux | output | 1 | Aux interrupt level |
| xlatEn | output | 1 | Scan-code translation request |

## Verification
The assertions assume that the host never raises `hostWr` and `hostRd` in the same cycle, that each strobe lasts exactly one clock, and that the two queue flags are clean synchronous levels. The bench drives every access through a single task that holds one strobe for one cycle. It changes the queue flags only at falling edges, so every property sees the kind of traffic a well-behaved host bus would deliver.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int BW = 8;

  localparam logic [BW-1:0] CMD_RD_MODE  = 8'h20;
  localparam logic [BW-1:0] CMD_WR_MODE  = 8'h60;
  localparam logic [BW-1:0] CMD_AUX_OFF  = 8'hA7;
  localparam logic [BW-1:0] CMD_AUX_ON   = 8'hA8;
  localparam logic [BW-1:0] CMD_AUX_TST  = 8'hA9;
  localparam logic [BW-1:0] CMD_SELFTEST = 8'hAA;
  localparam logic [BW-1:0] CMD_KBD_TST  = 8'hAB;
  localparam logic [BW-1:0] CMD_KBD_OFF  = 8'hAD;
  localparam logic [BW-1:0] CMD_KBD_ON   = 8'hAE;
  localparam logic [BW-1:0] CMD_RD_IN    = 8'hC0;
  localparam logic [BW-1:0] CMD_WR_PORT  = 8'hD1;
  localparam logic [BW-1:0] CMD_WR_KQ    = 8'hD2;
  localparam logic [BW-1:0] CMD_WR_AQ    = 8'hD3;
  localparam logic [BW-1:0] CMD_WR_ADEV  = 8'hD4;

  localparam logic [BW-1:0] RESET_MODE = 8'h03;

  typedef enum logic [1:0] {SRC_MODE, SRC_CONST, SRC_DATA} src_e;

  typedef struct packed {
    logic           loadMode;
    logic           setSelf;
    logic           setCmd;
    logic           clrCmd;
    logic           setAuxDis;
    logic           clrAuxDis;
    logic           setKbdDis;
    logic           clrKbdDis;
    logic           pushKbd;
    logic           pushAux;
    logic           fwdKbd;
    logic           fwdAux;
    logic           wrPort;
    src_e           src;
    logic [BW-1:0]  constByte;
  } strobe_t;
endpackage

// File: rtl/kbc_ctrl.sv
module kbc_ctrl
  import kbc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hostWr,
  input  logic          hostSel,
  input  logic [BW-1:0] hostWdata,
  output strobe_t       stb
);
  logic [BW-1:0] pendCmd;
  logic cmdWrite, dataWrite, isArming;

  assign cmdWrite  = hostWr &&  hostSel;
  assign dataWrite = hostWr && !hostSel;
  assign isArming  = (hostWdata == CMD_WR_MODE) || (hostWdata == CMD_WR_PORT) ||
                     (hostWdata == CMD_WR_KQ)   || (hostWdata == CMD_WR_AQ)   ||
                     (hostWdata == CMD_WR_ADEV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    pendCmd <= '0;
    else if (cmdWrite && isArming) pendCmd <= hostWdata;
    else if (dataWrite)            pendCmd <= '0;
  end

  always_comb begin
    stb = '0;
    stb.src = SRC_DATA;
    if (cmdWrite) begin
      stb.setCmd = 1'b1;
      unique case (hostWdata)
        CMD_RD_MODE:  begin stb.pushKbd = 1'b1; stb.src = SRC_MODE; end
        CMD_AUX_OFF:  stb.setAuxDis = 1'b1;
        CMD_AUX_ON:   stb.clrAuxDis = 1'b1;
        CMD_KBD_OFF:  stb.setKbdDis = 1'b1;
        CMD_KBD_ON:   stb.clrKbdDis = 1'b1;
        CMD_SELFTEST: begin
          stb.setSelf = 1'b1; stb.pushKbd = 1'b1;
          stb.src = SRC_CONST; stb.constByte = 8'h55;
        end
        CMD_AUX_TST, CMD_KBD_TST: begin
          stb.pushKbd = 1'b1; stb.src = SRC_CONST; stb.constByte = 8'h00;
        end
        CMD_RD_IN: begin
          stb.pushKbd = 1'b1; stb.src = SRC_CONST; stb.constByte = 8'h80;
        end
        default: ;
      endcase
    end else if (dataWrite) begin
      stb.clrCmd = 1'b1;
      unique case (pendCmd)
        CMD_WR_MODE: stb.loadMode = 1'b1;
        CMD_WR_PORT: stb.wrPort   = 1'b1;
        CMD_WR_KQ:   stb.pushKbd  = 1'b1;
        CMD_WR_AQ:   stb.pushAux  = 1'b1;
        CMD_WR_ADEV: stb.fwdAux   = 1'b1;
        default:     stb.fwdKbd   = 1'b1;
      endcase
    end
  end

  // R4: any data write leaves nothing armed
  p_pend_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dataWrite |=> (pendCmd == '0));
  // R4: a non-arming command keeps the armed target
  p_pend_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdWrite && !isArming) |=> $stable(pendCmd));
endmodule

// File: rtl/kbc_dpath.sv
module kbc_dpath
  import kbc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  strobe_t       stb,
  input  logic          hostRd,
  input  logic          hostSel,
  input  logic [BW-1:0] hostWdata,
  input  logic          kbdHasData,
  input  logic          auxHasData,
  output logic [BW-1:0] rdData,
  output logic          kbdPush,
  output logic          auxPush,
  output logic          kbdFwd,
  output logic          auxFwd,
  output logic          outPortWr,
  output logic [BW-1:0] outByte,
  output logic          irqKbd,
  output logic          irqAux,
  output logic          xlatEn
);
  logic [BW-1:0] modeReg, statusNow;
  logic selfOk, cmdFlag, auxOnly;

  assign auxOnly   = auxHasData && !kbdHasData;
  assign statusNow = {2'b00, auxOnly, 1'b1, cmdFlag, selfOk, 1'b0, kbdHasData | auxHasData};
  assign irqKbd    = kbdHasData && modeReg[0] && !modeReg[4];
  assign irqAux    = auxOnly && modeReg[1];
  assign xlatEn    = modeReg[6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeReg <= RESET_MODE;
      selfOk <= 1'b0; cmdFlag <= 1'b1;
      rdData <= '0; outByte <= '0;
      kbdPush <= 1'b0; auxPush <= 1'b0; kbdFwd <= 1'b0;
      auxFwd <= 1'b0; outPortWr <= 1'b0;
    end else begin
      kbdPush   <= stb.pushKbd;
      auxPush   <= stb.pushAux;
      kbdFwd    <= stb.fwdKbd;
      auxFwd    <= stb.fwdAux;
      outPortWr <= stb.wrPort;
      unique case (stb.src)
        SRC_MODE:  outByte <= modeReg;
        SRC_CONST: outByte <= stb.constByte;
        default:   outByte <= hostWdata;
      endcase
      if (stb.loadMode)       modeReg    <= hostWdata;
      else begin
        if (stb.setAuxDis)    modeReg[5] <= 1'b1;
        if (stb.clrAuxDis)    modeReg[5] <= 1'b0;
        if (stb.setKbdDis)    modeReg[4] <= 1'b1;
        if (stb.clrKbdDis)    modeReg[4] <= 1'b0;
      end
      if (stb.setSelf) selfOk  <= 1'b1;
      if (stb.setCmd)  cmdFlag <= 1'b1;
      if (stb.clrCmd)  cmdFlag <= 1'b0;
      if (hostRd && hostSel) rdData <= statusNow;
    end
  end

  p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({kbdPush, auxPush, kbdFwd, auxFwd, outPortWr}));
  p_irq_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irqAux |-> !irqKbd);
  p_self_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    selfOk |=> selfOk);
  p_cmd_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stb.setCmd |=> cmdFlag);
  p_data_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hostRd && !hostSel) |=> $stable(rdData));
endmodule

// File: rtl/kbc_hostregs.sv
module kbc_hostregs
  import kbc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hostWr,
  input  logic          hostRd,
  input  logic          hostSel,
  input  logic [BW-1:0] hostWdata,
  input  logic          kbdHasData,
  input  logic          auxHasData,
  output logic [BW-1:0] rdData,
  output logic          kbdPush,
  output logic          auxPush,
  output logic          kbdFwd,
  output logic          auxFwd,
  output logic          outPortWr,
  output logic [BW-1:0] outByte,
  output logic          irqKbd,
  output logic          irqAux,
  output logic          xlatEn
);
  strobe_t stb;

  kbc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .hostWr(hostWr), .hostSel(hostSel),
    .hostWdata(hostWdata), .stb(stb)
  );

  kbc_dpath u_dpath (
    .clk(clk), .rst_n(rst_n), .stb(stb), .hostRd(hostRd), .hostSel(hostSel),
    .hostWdata(hostWdata), .kbdHasData(kbdHasData), .auxHasData(auxHasData),
    .rdData(rdData), .kbdPush(kbdPush), .auxPush(auxPush), .kbdFwd(kbdFwd),
    .auxFwd(auxFwd), .outPortWr(outPortWr), .outByte(outByte),
    .irqKbd(irqKbd), .irqAux(irqAux), .xlatEn(xlatEn)
  );

  // R5: a keyboard-device forward only follows a data-port write
  p_fwd_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    kbdFwd |-> $past(hostWr && !hostSel));
endmodule

// File: tb/sim_kbc_hostregs.sv
module sim_kbc_hostregs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hostWr = 1'b0, hostRd = 1'b0, hostSel = 1'b0;
  logic [7:0] hostWdata = '0;
  logic kbdHasData = 1'b0, auxHasData = 1'b0;
  logic [7:0] rdData, outByte;
  logic kbdPush, auxPush, kbdFwd, auxFwd, outPortWr, irqKbd, irqAux, xlatEn;

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  // behavioural model state
  int mMode = 8'h03, mSelf = 0, mCmd = 1, mPend = 0, mRd = 0;
  int eKp, eAp, eKf, eAf, eOw, eByte;

  always #10 clk = ~clk;

  kbc_hostregs u0 (
    .clk(clk), .rst_n(rst_n), .hostWr(hostWr), .hostRd(hostRd), .hostSel(hostSel),
    .hostWdata(hostWdata), .kbdHasData(kbdHasData), .auxHasData(auxHasData),
    .rdData(rdData), .kbdPush(kbdPush), .auxPush(auxPush), .kbdFwd(kbdFwd),
    .auxFwd(auxFwd), .outPortWr(outPortWr), .outByte(outByte),
    .irqKbd(irqKbd), .irqAux(irqAux), .xlatEn(xlatEn)
  );

  task automatic chk(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int statusByte(bit kh, bit ah);
    return ((ah && !kh) << 5) | (1 << 4) | (mCmd << 3) | (mSelf << 2) | (kh | ah);
  endfunction

  // one host cycle: kind 0 idle, 1 write, 2 read
  task automatic step(string req, int kind, bit sel, int data, bit kh, bit ah);
    @(negedge clk);
    hostWr = (kind == 1); hostRd = (kind == 2); hostSel = sel;
    hostWdata = data[7:0]; kbdHasData = kh; auxHasData = ah;
    eKp = 0; eAp = 0; eKf = 0; eAf = 0; eOw = 0; eByte = -1;
    if (kind == 2 && sel) mRd = statusByte(kh, ah);
    if (kind == 1 && sel) begin
      mCmd = 1;
      case (data)
        'h20: begin eKp = 1; eByte = mMode; end
        'h60, 'hD1, 'hD2, 'hD3, 'hD4: mPend = data;
        'hA7: mMode |= 'h20;
        'hA8: mMode &= ~'h20;
        'hAD: mMode |= 'h10;
        'hAE: mMode &= ~'h10;
        'hA9, 'hAB: begin eKp = 1; eByte = 0; end
        'hAA: begin mSelf = 1; eKp = 1; eByte = 'h55; end
        'hC0: begin eKp = 1; eByte = 'h80; end
        default: ;
      endcase
    end else if (kind == 1) begin
      mCmd = 0;
      eByte = data;
      case (mPend)
        'h60: begin mMode = data; eByte = -1; end
        'hD1: eOw = 1;
        'hD2: eKp = 1;
        'hD3: eAp = 1;
        'hD4: eAf = 1;
        default: eKf = 1;
      endcase
      mPend = 0;
    end
    @(posedge clk); #1;
    hostWr = 1'b0; hostRd = 1'b0;
    chk(req, "kbdPush", kbdPush, eKp);
    chk(req, "auxPush", auxPush, eAp);
    chk(req, "kbdFwd", kbdFwd, eKf);
    chk(req, "auxFwd", auxFwd, eAf);
    chk(req, "outPortWr", outPortWr, eOw);
    if (eByte >= 0) chk(req, "outByte", outByte, eByte);
    chk(req, "rdData", rdData, mRd);
    chk("R8", "irqKbd", irqKbd, kh && mMode[0] && !mMode[4]);
    chk("R8", "irqAux", irqAux, ah && !kh && mMode[1]);
    chk("R9", "xlatEn", xlatEn, mMode[6]);
  endtask

  task automatic wrCmd(string req, int c);  step(req, 1, 1, c, 0, 0); endtask
  task automatic wrData(string req, int d); step(req, 1, 0, d, 0, 0); endtask
  task automatic rdStat(string req);        step(req, 2, 1, 0, 0, 0); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step("R1", 0, 0, 0, 0, 0);          // reset state of strobes / xlatEn
    rdStat("R1");                       // status 0x18
    wrCmd("R1", 'h20);                  // mode 0x03 pushed (R3)
    wrData("R5", 'h3C);                 // nothing armed -> keyboard device
    rdStat("R10");                      // bit 3 cleared by data write
    wrCmd("R6", 'hAA);
    rdStat("R6");                       // 0x1C
    wrCmd("R6", 'hA9);
    wrCmd("R6", 'hAB);
    wrCmd("R6", 'hC0);
    wrCmd("R4", 'hD2); wrData("R4", 'h5A);
    wrCmd("R4", 'hD3); wrData("R4", 'hA5);
    wrCmd("R4", 'hD4); wrData("R4", 'h11);
    wrCmd("R4", 'hD1); wrData("R4", 'hDF);
    wrCmd("R4", 'h60); wrData("R4", 'h43);
    wrCmd("R3", 'h20);                  // pushes 0x43
    step("R9", 0, 0, 0, 0, 0);
    wrCmd("R4", 'hD2); wrCmd("R4", 'hAA); wrData("R4", 'h77); // armed survives
    wrData("R4", 'h78);                 // disarmed -> keyboard device
    wrCmd("R11", 'h12); wrCmd("R11", 'hF0); wrCmd("R11", 'hFF);
    rdStat("R11");
    step("R8", 0, 0, 0, 1, 0);
    step("R8", 0, 0, 0, 0, 1);
    step("R8", 0, 0, 0, 1, 1);
    step("R2", 2, 1, 0, 0, 1);          // aux only -> bits 5 and 0
    step("R2", 2, 1, 0, 1, 1);
    step("R2", 2, 0, 0, 0, 0);          // data read leaves rdData
    step("R7", 1, 1, 'hAD, 1, 0);
    step("R7", 1, 1, 'hAE, 1, 0);
    step("R7", 1, 1, 'hA7, 0, 1);
    wrCmd("R7", 'h20);                  // mode with bit 5 set
    step("R7", 1, 1, 'hA8, 0, 1);
    wrCmd("R7", 'h20);
    wrCmd("R4", 'h60); wrData("R4", 'h00);
    step("R8", 0, 0, 0, 1, 1);          // interrupts masked
    wrCmd("R12", 'hD3); step("R12", 0, 0, 0, 0, 0); wrData("R12", 'h99);
    step("R12", 0, 0, 0, 0, 0);         // strobe lasts one cycle
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule